// File: doc/BRIEF.md
# Single-Word Interrupt Aggregator

This block gathers a configurable group of interrupt source lines into one parent interrupt line. Software sees one 32-bit control word. The lower half of the word holds one read/write enable bit per source. The upper half holds one sticky status bit per source, placed exactly 16 bits above that source's enable bit. A status bit is recorded on a rising edge of its source, whether or not the source is enabled. It stays set until software writes a 1 to it.

The parent line is a registered OR across all sources of status AND enable, so the parent treats each source as a level interrupt. A typical handler reads the word, services each source that is both pending and enabled, and clears that source's status bit with a write-1. An enable-only update writes zeros in the status half, so no pending status is lost. Two parameters place the source field: `NUM_SRC` sets the number of sources and `SRC_BASE` sets the bit where the field starts. The defaults are 7 sources at bit 0. A layout such as 2 sources at bit 4 is also supported.

Top module: `shreg_irq_agg`

## Requirements
- R1: After reset, every bit of the read word is 0 and `irq_o` is 0.
- R2: Enable bit k of source i is word bit `SRC_BASE+i`. A write loads it from the written data. With no write, it keeps its value.
- R3: Status bit of source i is word bit `16+SRC_BASE+i`. It becomes 1 in the cycle after the clock edge that samples `src_i[i]` high when it was low at the edge before. It then stays 1 while the source is held high or falls, until it is cleared.
- R4: Writing 1 to a status bit clears it, and the cleared value is visible after that edge. Writing 0 to a status bit leaves it unchanged.
- R5: When a rising edge and a write-1 clear reach the same status bit at the same clock edge, the status bit ends up 1.
- R6: Word bits outside the enable field and the status field always read 0, and writes to them have no effect.
- R7: `irq_o` is registered. After each clock edge it equals the OR over all sources of (status AND enable) as held before that edge.
- R8: A status bit latches a rising edge even while its enable bit is 0. That source does not drive `irq_o` until it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt source lines, synchronous to clk |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Data for a write |
| reg_rdata | output | 32 | Current control word: enable field and status field; reading has no side effect |
| irq_o | output | 1 | Parent interrupt line |

## Verification
A wrong status or enable bit shows up at once on `reg_rdata`, in the cycle right after the faulty edge, because the read word is a direct view of both fields. The same fault reaches `irq_o` one cycle later, through its output register. A lost clear or a lost set therefore shows within two cycles. A misplaced field shows as a wrong bit position or a nonzero bit outside the field. A wrong choice between set and clear shows as a status bit that is 0 after a coincident edge and clear. The second instance, with its field at bit 4, shows the errors that come from the offset.

// File: rtl/shreg_irq_pkg.sv
package shreg_irq_pkg;
  localparam int REG_W    = 32;
  localparam int STAT_OFS = 16;

  // Mask of every implemented bit: enable field plus status field.
  function automatic logic [REG_W-1:0] field_mask(input int base, input int num);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < num; i++) begin
      m[base + i]            = 1'b1;
      m[STAT_OFS + base + i] = 1'b1;
    end
    return m;
  endfunction

  // Sticky status update: set has priority over write-1 clear.
  function automatic logic next_status(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/shreg_rise_det.sv
module shreg_rise_det #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src;
  end

  assign rise = src & ~prev_q;
endmodule

// File: rtl/shreg_status_bank.sv
module shreg_status_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status
);
  import shreg_irq_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[g] <= 1'b0;
      else        status[g] <= next_status(status[g], set[g], clr[g]);
    end
  end
endmodule

// File: rtl/shreg_enable_bank.sv
module shreg_enable_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [N-1:0] wfield,
  output logic [N-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en <= '0;
    else if (wr) en <= wfield;
  end
endmodule

// File: rtl/shreg_irq_agg.sv
module shreg_irq_agg #(
  parameter int NUM_SRC  = 7,
  parameter int SRC_BASE = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_o
);
  import shreg_irq_pkg::*;

  localparam int EN_LO   = SRC_BASE;
  localparam int STAT_LO = STAT_OFS + SRC_BASE;

  // Named internal events, brought out for the bound checker.
  logic [NUM_SRC-1:0] rise_ev;
  logic [NUM_SRC-1:0] clr_ev;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] en_q;
  logic               pend_any;

  shreg_rise_det #(.N(NUM_SRC)) u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .src  (src_i),
    .rise (rise_ev)
  );

  assign clr_ev = reg_wr ? reg_wdata[STAT_LO +: NUM_SRC] : '0;

  shreg_status_bank #(.N(NUM_SRC)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (rise_ev),
    .clr   (clr_ev),
    .status(status_q)
  );

  shreg_enable_bank #(.N(NUM_SRC)) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .wfield(reg_wdata[EN_LO +: NUM_SRC]),
    .en    (en_q)
  );

  assign pend_any = |(status_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pend_any;
  end

  always_comb begin
    reg_rdata                     = '0;
    reg_rdata[EN_LO +: NUM_SRC]   = en_q;
    reg_rdata[STAT_LO +: NUM_SRC] = status_q;
  end
endmodule

// File: rtl/shreg_irq_agg_chk.sv
module shreg_irq_agg_chk #(
  parameter int NUM_SRC  = 7,
  parameter int SRC_BASE = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [31:0]        reg_rdata,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] rise_ev,
  input logic [NUM_SRC-1:0] clr_ev,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] en_q
);
  import shreg_irq_pkg::*;
  localparam logic [31:0] FMASK = field_mask(SRC_BASE, NUM_SRC);

  a_r2_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(en_q));

  a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_ev) |=> ((status_q & $past(rise_ev)) == $past(rise_ev)));

  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(rise_ev)) == '0));

  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_ev & ~rise_ev)) |=> ((status_q & $past(clr_ev & ~rise_ev)) == '0));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_ev & rise_ev)) |=> ((status_q & $past(clr_ev & rise_ev)) == $past(clr_ev & rise_ev)));

  a_r6_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata & ~FMASK) == '0));

  a_r7_irq_lags: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(status_q & en_q)));
endmodule

bind shreg_irq_agg shreg_irq_agg_chk #(.NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_rdata(reg_rdata),
  .irq_o    (irq_o),
  .rise_ev  (rise_ev),
  .clr_ev   (clr_ev),
  .status_q (status_q),
  .en_q     (en_q)
);

// File: tb/shreg_irq_agg_bench.sv
`timescale 1ns/1ps
module shreg_irq_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  src = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [1:0]  src_b = '0;
  logic        wr_b = 1'b0;
  logic [31:0] wdata_b = '0;
  logic [31:0] rdata_b;
  logic        irq_b;

  int checks = 0;
  int fails  = 0;

  // Bench-side models.
  logic [6:0] m_en = '0, m_st = '0, m_prev = '0;
  logic       m_irq = 1'b0;
  logic [1:0] b_en = '0, b_st = '0, b_prev = '0;
  logic       b_irq = 1'b0;

  always #2 clk = ~clk;

  shreg_irq_agg u_shreg_irq_agg (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr(wr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  shreg_irq_agg #(.NUM_SRC(2), .SRC_BASE(4)) u_shreg_irq_agg_b (
    .clk(clk), .rst_n(rst_n), .src_i(src_b), .reg_wr(wr_b),
    .reg_wdata(wdata_b), .reg_rdata(rdata_b), .irq_o(irq_b)
  );

  function automatic logic [31:0] word7(input logic [6:0] en, input logic [6:0] st);
    return (32'(st) << 16) | 32'(en);
  endfunction

  function automatic logic [31:0] word2(input logic [1:0] en, input logic [1:0] st);
    return (32'(st) << 20) | (32'(en) << 4);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] s, input logic w, input logic [31:0] d, input string req);
    logic [6:0] rise;
    @(negedge clk);
    src = s; wr = w; wdata = d;
    @(posedge clk);
    m_irq  = |(m_st & m_en);
    rise   = s & ~m_prev;
    m_prev = s;
    m_st   = rise | (m_st & ~(w ? d[22:16] : 7'h0));
    if (w) m_en = d[6:0];
    #1;
    check(rdata, word7(m_en, m_st), {req, " word"});
    check({31'b0, irq}, {31'b0, m_irq}, {req, " R7 irq"});
  endtask

  task automatic step_b(input logic [1:0] s, input logic w, input logic [31:0] d, input string req);
    logic [1:0] rise;
    @(negedge clk);
    src_b = s; wr_b = w; wdata_b = d;
    @(posedge clk);
    b_irq  = |(b_st & b_en);
    rise   = s & ~b_prev;
    b_prev = s;
    b_st   = rise | (b_st & ~(w ? d[21:20] : 2'b0));
    if (w) b_en = d[5:4];
    #1;
    check(rdata_b, word2(b_en, b_st), {req, " offset word"});
    check({31'b0, irq_b}, {31'b0, b_irq}, {req, " R7 offset irq"});
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rdata, 32'h0, "R1 reset word");
    check({31'b0, irq}, 32'h0, "R1 reset irq");
    check(rdata_b, 32'h0, "R1 reset offset word");

    // Directed corner cases on the default layout.
    step(7'h01, 1'b0, 32'h0, "R3 R8 rise while disabled");
    step(7'h01, 1'b0, 32'h0, "R3 held high no change");
    step(7'h00, 1'b0, 32'h0, "R3 sticky after fall");
    step(7'h00, 1'b1, 32'h0000_007F, "R2 enable write");
    step(7'h00, 1'b0, 32'hFFFF_FFFF, "R2 no write ignored data");
    step(7'h00, 1'b1, 32'h0000_007F, "R4 zero leaves status");
    step(7'h00, 1'b1, 32'h0001_007F, "R4 write one clears");
    step(7'h00, 1'b0, 32'h0, "R7 irq drops after clear");
    step(7'h04, 1'b1, 32'h0004_007F, "R5 set wins over clear");
    step(7'h04, 1'b1, 32'hFFFF_FFFF, "R6 all ones write");
    step(7'h00, 1'b1, 32'hFF80_FF80, "R6 outside bits only");

    // Constrained random traffic.
    for (int i = 0; i < 600; i++) begin
      logic [6:0]  s;
      logic        w;
      logic [31:0] d;
      s = 7'($urandom) & 7'($urandom);
      w = ($urandom % 4) == 0;
      d = $urandom;
      step(s, w, d, "R2 R3 R4 R5 R6 random");
    end

    // Offset layout: 2 sources starting at bit 4.
    step_b(2'b00, 1'b1, 32'h0000_FFFF, "R2 R6 offset enable");
    step_b(2'b10, 1'b0, 32'h0, "R3 offset rise at bit 21");
    step_b(2'b10, 1'b0, 32'h0, "R7 offset irq rises");
    step_b(2'b11, 1'b1, 32'h0020_0030, "R5 R4 offset clear with new rise");
    step_b(2'b00, 1'b1, 32'h0010_0000, "R8 offset disable and clear");
    step_b(2'b01, 1'b0, 32'h0, "R8 offset latch while disabled");
    for (int i = 0; i < 200; i++) begin
      logic [1:0]  s;
      logic        w;
      logic [31:0] d;
      s = 2'($urandom);
      w = ($urandom % 3) == 0;
      d = $urandom;
      step_b(s, w, d, "R3 R4 R6 offset random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule